// File: doc/BRIEF.md
# Status Flag Register and Branch Resolution Unit

This block keeps the eight processor condition flags in one register and resolves the control-flow effect of each instruction it is handed. It applies masked flag updates coming from the arithmetic unit. It executes the flag set and flag clear operations, and it moves single bits between a data register and the transfer flag. For every conditional branch or skip it decides whether the condition holds, then works out the following program-counter value and the number of cycles the instruction costs.

Bit positions in the flag register are fixed: carry 0, zero 1, negative 2, overflow 3, sign 4, half-carry 5, transfer 6, interrupt enable 7. The instruction interface is plain: one operation per clock, qualified by `op_valid`. There is no ready signal and no back-pressure, so the unit accepts every cycle. Its results are registered and appear exactly one cycle later, qualified by `res_valid`. The results last one cycle and are not held for a consumer. A condition is always judged on the flags as they stood at the start of the operation's cycle.

Operation codes on `op_code`: 0 no-op, 1 flag set, 2 flag clear, 3 bit store to transfer flag, 4 bit load from transfer flag, 5 branch if flag set, 6 branch if flag clear, 7 signed greater-or-equal branch, 8 signed less-than branch, 9 skip if equal, 10 skip if register bit set, 11 skip if register bit clear, 12 interrupt return.

Top module: `sreg_branch_unit`

## Requirements
- R1: After reset the flag register reads 0x00, and `res_valid` and `taken` are 0.
- R2: Flag set (code 1) writes 1 and flag clear (code 2) writes 0 to the flag at `flag_idx`. The bit positions are C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7. All other flags keep their values.
- R3: While `alu_we` is 1, each flag whose `alu_mask` bit is 1 takes the matching `alu_flags` bit, and every other flag holds. When an accepted instruction writes the same flag in the same cycle, the instruction's value wins.
- R4: Bit store (code 3) copies bit `bit_idx` of `reg_val` into T (bit 6) and leaves the other flags unchanged.
- R5: Bit load (code 4) returns on `bld_value` the value of `reg_val` with bit `bit_idx` replaced by T, and leaves the flag register unchanged.
- R6: Branch-if-set (code 5) and branch-if-clear (code 6) test the flag at `flag_idx`. When taken, the unit gives `taken`=1, `next_pc` = `pc_in` + sign-extended 7-bit `br_ofs` + 1, and `cycles`=2. Otherwise it gives `taken`=0, `next_pc` = `pc_in`+1 and `cycles`=1.
- R7: Signed greater-or-equal (code 7) is taken when N XOR V is 0, and signed less-than (code 8) when it is 1. The stored S bit plays no part. Step and cycle count follow R6.
- R8: Skip-if-equal (code 9, `reg_val`==`cmp_val`), skip-if-bit-set (code 10) and skip-if-bit-clear (code 11) on `reg_val[bit_idx]` work as follows. When the condition holds, `next_pc` = `pc_in`+3 and `cycles`=3 if `next_long` is 1, and `pc_in`+2 with `cycles`=2 otherwise. When it fails, `next_pc` = `pc_in`+1 and `cycles`=1.
- R9: Interrupt return (code 12) sets I and reports `taken`=0, `next_pc` = `pc_in`+1 and `cycles`=4.
- R10: Results appear one cycle after the operation, with `res_valid`=1 only then. A condition uses the flags as they were before that cycle's edge, so a same-cycle `alu_we` update is not seen by the branch.
- R11: Next-PC arithmetic wraps modulo 2^16 for both positive and negative offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_we | input | 1 | Apply masked flag update |
| alu_mask | input | 8 | Flags affected by the update |
| alu_flags | input | 8 | New flag values from the arithmetic unit |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation code |
| flag_idx | input | 3 | Flag selected by set, clear and branch |
| bit_idx | input | 3 | Register bit selected by store, load and skip |
| reg_val | input | 8 | Register operand |
| cmp_val | input | 8 | Second operand for skip-if-equal |
| pc_in | input | 16 | Address of the current instruction |
| br_ofs | input | 7 | Signed branch offset |
| next_long | input | 1 | Following instruction is two words long |
| sreg | output | 8 | Flag register contents |
| res_valid | output | 1 | Result fields are valid |
| taken | output | 1 | Branch taken or skip performed |
| next_pc | output | 16 | Resolved next program counter |
| cycles | output | 3 | Cycle cost of the instruction |
| bld_value | output | 8 | Register value after bit load |

## Verification
An arithmetic flag update and a flag-reading branch can share one clock edge. The bench provokes this by raising `alu_we` to set carry in the very cycle that a branch-if-carry-set is issued. It then judges the outcome at two points: the branch must report not taken, because it reads the old flags, and the flag register must already show carry set. An identical branch issued one cycle later must be taken. The same edge is also used to collide a masked update with a flag set or clear on the same bit, where the instruction must prevail.

// File: rtl/sbu_pkg.sv
package sbu_pkg;
  localparam int NFLAGS = 8;
  localparam int FIW    = 3;
  localparam int CYC_W  = 3;

  localparam int FLAG_C = 0;
  localparam int FLAG_Z = 1;
  localparam int FLAG_N = 2;
  localparam int FLAG_V = 3;
  localparam int FLAG_S = 4;
  localparam int FLAG_H = 5;
  localparam int FLAG_T = 6;
  localparam int FLAG_I = 7;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_FSET = 4'd1,
    OP_FCLR = 4'd2,
    OP_BST  = 4'd3,
    OP_BLD  = 4'd4,
    OP_BRS  = 4'd5,
    OP_BRC  = 4'd6,
    OP_BRGE = 4'd7,
    OP_BRLT = 4'd8,
    OP_SKEQ = 4'd9,
    OP_SKBS = 4'd10,
    OP_SKBC = 4'd11,
    OP_RETI = 4'd12
  } op_e;
endpackage

// File: rtl/sbu_flag_reg.sv
module sbu_flag_reg
  import sbu_pkg::*;
#(
  parameter int DW  = 8,
  parameter int BIW = $clog2(DW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alu_we,
  input  logic [NFLAGS-1:0] alu_mask,
  input  logic [NFLAGS-1:0] alu_flags,
  input  logic              op_valid,
  input  op_e               op,
  input  logic [FIW-1:0]    flag_idx,
  input  logic [BIW-1:0]    bit_idx,
  input  logic [DW-1:0]     reg_val,
  output logic [NFLAGS-1:0] sreg_q
);
  logic [NFLAGS-1:0] nxt;

  always_comb begin
    nxt = sreg_q;
    if (alu_we) nxt = (sreg_q & ~alu_mask) | (alu_flags & alu_mask);
    if (op_valid) begin
      case (op)
        OP_FSET: nxt[flag_idx] = 1'b1;
        OP_FCLR: nxt[flag_idx] = 1'b0;
        OP_BST:  nxt[FLAG_T]   = reg_val[bit_idx];
        OP_RETI: nxt[FLAG_I]   = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sreg_q <= '0;
    else        sreg_q <= nxt;
  end

  AST_FSET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op == OP_FSET |=> sreg_q[$past(flag_idx)] == 1'b1); // R2
  AST_FCLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op == OP_FCLR |=> sreg_q[$past(flag_idx)] == 1'b0); // R3
  AST_BLD_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op == OP_BLD && !alu_we |=> $stable(sreg_q)); // R5
  AST_RETI_SETS_I: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op == OP_RETI |=> sreg_q[FLAG_I]); // R9
endmodule

// File: rtl/sbu_cond_eval.sv
module sbu_cond_eval
  import sbu_pkg::*;
#(
  parameter int DW  = 8,
  parameter int BIW = $clog2(DW)
) (
  input  op_e               op,
  input  logic [NFLAGS-1:0] flags,
  input  logic [FIW-1:0]    flag_idx,
  input  logic [BIW-1:0]    bit_idx,
  input  logic [DW-1:0]     reg_val,
  input  logic [DW-1:0]     cmp_val,
  output logic              is_branch,
  output logic              is_skip,
  output logic              holds
);
  logic signed_lt;
  assign signed_lt = flags[FLAG_N] ^ flags[FLAG_V];

  always_comb begin
    is_branch = 1'b0;
    is_skip   = 1'b0;
    holds     = 1'b0;
    case (op)
      OP_BRS:  begin is_branch = 1'b1; holds = flags[flag_idx];         end
      OP_BRC:  begin is_branch = 1'b1; holds = !flags[flag_idx];        end
      OP_BRGE: begin is_branch = 1'b1; holds = !signed_lt;              end
      OP_BRLT: begin is_branch = 1'b1; holds = signed_lt;               end
      OP_SKEQ: begin is_skip   = 1'b1; holds = (reg_val == cmp_val);    end
      OP_SKBS: begin is_skip   = 1'b1; holds = reg_val[bit_idx];        end
      OP_SKBC: begin is_skip   = 1'b1; holds = !reg_val[bit_idx];       end
      default: ;
    endcase
  end
endmodule

// File: rtl/sbu_pc_step.sv
module sbu_pc_step
  import sbu_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int OFS_W = 7
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [OFS_W-1:0] ofs,
  input  logic             next_long,
  input  logic             is_branch,
  input  logic             is_skip,
  input  logic             holds,
  input  logic             is_reti,
  output logic [PC_W-1:0]  npc,
  output logic [CYC_W-1:0] cyc,
  output logic             take
);
  localparam int EXT = PC_W - OFS_W;
  logic [PC_W-1:0] ofs_ext;

  generate
    if (EXT > 0) begin : g_sext
      assign ofs_ext = {{EXT{ofs[OFS_W-1]}}, ofs};
    end else begin : g_trunc
      assign ofs_ext = ofs[PC_W-1:0];
    end
  endgenerate

  always_comb begin
    take = (is_branch || is_skip) && holds;
    npc  = pc + PC_W'(1);
    cyc  = CYC_W'(1);
    if (is_branch && holds) begin
      npc = pc + ofs_ext + PC_W'(1);
      cyc = CYC_W'(2);
    end else if (is_skip && holds) begin
      npc = pc + (next_long ? PC_W'(3) : PC_W'(2));
      cyc = next_long ? CYC_W'(3) : CYC_W'(2);
    end
    if (is_reti) cyc = CYC_W'(4);
  end
endmodule

// File: rtl/sreg_branch_unit.sv
module sreg_branch_unit
  import sbu_pkg::*;
#(
  parameter int DW    = 8,
  parameter int PC_W  = 16,
  parameter int OFS_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alu_we,
  input  logic [7:0]        alu_mask,
  input  logic [7:0]        alu_flags,
  input  logic              op_valid,
  input  logic [3:0]        op_code,
  input  logic [2:0]        flag_idx,
  input  logic [2:0]        bit_idx,
  input  logic [DW-1:0]     reg_val,
  input  logic [DW-1:0]     cmp_val,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [OFS_W-1:0]  br_ofs,
  input  logic              next_long,
  output logic [7:0]        sreg,
  output logic              res_valid,
  output logic              taken,
  output logic [PC_W-1:0]   next_pc,
  output logic [2:0]        cycles,
  output logic [DW-1:0]     bld_value
);
  localparam int BIW = $clog2(DW);

  op_e              op;
  logic             is_branch, is_skip, holds, take;
  logic [PC_W-1:0]  npc;
  logic [CYC_W-1:0] cyc;
  logic [DW-1:0]    bld_c;

  assign op = op_e'(op_code);

  sbu_flag_reg #(.DW(DW), .BIW(BIW)) u_flags (
    .clk(clk), .rst_n(rst_n), .alu_we(alu_we), .alu_mask(alu_mask),
    .alu_flags(alu_flags), .op_valid(op_valid), .op(op),
    .flag_idx(flag_idx), .bit_idx(bit_idx[BIW-1:0]), .reg_val(reg_val),
    .sreg_q(sreg)
  );

  sbu_cond_eval #(.DW(DW), .BIW(BIW)) u_cond (
    .op(op), .flags(sreg), .flag_idx(flag_idx), .bit_idx(bit_idx[BIW-1:0]),
    .reg_val(reg_val), .cmp_val(cmp_val), .is_branch(is_branch),
    .is_skip(is_skip), .holds(holds)
  );

  sbu_pc_step #(.PC_W(PC_W), .OFS_W(OFS_W)) u_step (
    .pc(pc_in), .ofs(br_ofs), .next_long(next_long), .is_branch(is_branch),
    .is_skip(is_skip), .holds(holds), .is_reti(op == OP_RETI),
    .npc(npc), .cyc(cyc), .take(take)
  );

  always_comb begin
    bld_c = reg_val;
    bld_c[bit_idx[BIW-1:0]] = sreg[FLAG_T];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      taken     <= 1'b0;
      next_pc   <= '0;
      cycles    <= '0;
      bld_value <= '0;
    end else begin
      res_valid <= op_valid;
      taken     <= op_valid && take;
      if (op_valid) begin
        next_pc   <= npc;
        cycles    <= cyc;
        bld_value <= bld_c;
      end
    end
  end

  AST_NO_RESULT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> !taken); // R10
  AST_TAKEN_COSTS_MORE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && taken |-> cycles == 3'd2 || cycles == 3'd3); // R6
  AST_NOTAKEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !taken |-> next_pc == PC_W'($past(pc_in) + 1'b1)); // R8
  AST_VALID_FOLLOWS_OP: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid); // R10
endmodule

// File: tb/sreg_branch_unit_bench.sv
`timescale 1ns/1ps
module sreg_branch_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alu_we = 1'b0;
  logic [7:0]  alu_mask = '0, alu_flags = '0;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = '0;
  logic [2:0]  flag_idx = '0, bit_idx = '0;
  logic [7:0]  reg_val = '0, cmp_val = '0;
  logic [15:0] pc_in = '0;
  logic [6:0]  br_ofs = '0;
  logic        next_long = 1'b0;
  logic [7:0]  sreg;
  logic        res_valid, taken;
  logic [15:0] next_pc;
  logic [2:0]  cycles;
  logic [7:0]  bld_value;

  int n_checks = 0;
  int n_fails  = 0;

  always #2.5 clk = ~clk;

  sreg_branch_unit u_sreg_branch_unit (
    .clk(clk), .rst_n(rst_n), .alu_we(alu_we), .alu_mask(alu_mask),
    .alu_flags(alu_flags), .op_valid(op_valid), .op_code(op_code),
    .flag_idx(flag_idx), .bit_idx(bit_idx), .reg_val(reg_val),
    .cmp_val(cmp_val), .pc_in(pc_in), .br_ofs(br_ofs), .next_long(next_long),
    .sreg(sreg), .res_valid(res_valid), .taken(taken), .next_pc(next_pc),
    .cycles(cycles), .bld_value(bld_value)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic [3:0]  op;
    logic [2:0]  fidx;
    logic [2:0]  bidx;
    logic [7:0]  rv;
    logic [7:0]  cv;
    logic [15:0] pc;
    logic [6:0]  ofs;
    logic        nl;
    logic [7:0]  pre;
    logic        e_tk;
    logic [15:0] e_pc;
    logic [2:0]  e_cy;
    logic [7:0]  e_sr;
    logic [7:0]  e_bld;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    //  req    op    fidx  bidx  rv      cv      pc         ofs     nl    pre     tk    e_pc       cy    e_sr    e_bld
    '{8'd2,  4'd1, 3'd7, 3'd0, 8'h00, 8'h00, 16'h0100, 7'h00, 1'b0, 8'h00, 1'b0, 16'h0101, 3'd1, 8'h80, 8'h00}, // R2 set I
    '{8'd2,  4'd2, 3'd1, 3'd0, 8'h00, 8'h00, 16'h0200, 7'h00, 1'b0, 8'hFF, 1'b0, 16'h0201, 3'd1, 8'hFD, 8'h00}, // R2 clear Z
    '{8'd4,  4'd3, 3'd0, 3'd5, 8'h20, 8'h00, 16'h0010, 7'h00, 1'b0, 8'h00, 1'b0, 16'h0011, 3'd1, 8'h40, 8'h00}, // R4 store 1
    '{8'd4,  4'd3, 3'd0, 3'd0, 8'hFE, 8'h00, 16'h0010, 7'h00, 1'b0, 8'hFF, 1'b0, 16'h0011, 3'd1, 8'hBF, 8'h00}, // R4 store 0
    '{8'd5,  4'd4, 3'd0, 3'd3, 8'h00, 8'h00, 16'h0020, 7'h00, 1'b0, 8'h40, 1'b0, 16'h0021, 3'd1, 8'h40, 8'h08}, // R5 load 1
    '{8'd5,  4'd4, 3'd0, 3'd7, 8'hFF, 8'h00, 16'h0020, 7'h00, 1'b0, 8'hBF, 1'b0, 16'h0021, 3'd1, 8'hBF, 8'h7F}, // R5 load 0
    '{8'd6,  4'd5, 3'd0, 3'd0, 8'h00, 8'h00, 16'h0100, 7'h05, 1'b0, 8'h01, 1'b1, 16'h0106, 3'd2, 8'h01, 8'h00}, // R6 lower taken
    '{8'd6,  4'd5, 3'd0, 3'd0, 8'h00, 8'h00, 16'h0100, 7'h05, 1'b0, 8'h00, 1'b0, 16'h0101, 3'd1, 8'h00, 8'h00}, // R6 lower not
    '{8'd6,  4'd6, 3'd1, 3'd0, 8'h00, 8'h00, 16'h0100, 7'h7C, 1'b0, 8'h00, 1'b1, 16'h00FD, 3'd2, 8'h00, 8'h00}, // R6 back -4
    '{8'd7,  4'd7, 3'd0, 3'd0, 8'h00, 8'h00, 16'h0050, 7'h3F, 1'b0, 8'h0C, 1'b1, 16'h0090, 3'd2, 8'h0C, 8'h00}, // R7 ge N=V=1
    '{8'd7,  4'd8, 3'd0, 3'd0, 8'h00, 8'h00, 16'h0050, 7'h40, 1'b0, 8'h04, 1'b1, 16'h0011, 3'd2, 8'h04, 8'h00}, // R7 lt, S=0
    '{8'd7,  4'd7, 3'd0, 3'd0, 8'h00, 8'h00, 16'h0050, 7'h10, 1'b0, 8'h14, 1'b0, 16'h0051, 3'd1, 8'h14, 8'h00}, // R7 ge not, S=1
    '{8'd8,  4'd9, 3'd0, 3'd0, 8'h5A, 8'h5A, 16'h0300, 7'h00, 1'b0, 8'h00, 1'b1, 16'h0302, 3'd2, 8'h00, 8'h00}, // R8 eq short
    '{8'd8,  4'd9, 3'd0, 3'd0, 8'h5A, 8'h5B, 16'h0300, 7'h00, 1'b0, 8'h00, 1'b0, 16'h0301, 3'd1, 8'h00, 8'h00}, // R8 ne
    '{8'd8,  4'd10,3'd0, 3'd7, 8'h80, 8'h00, 16'h0300, 7'h00, 1'b1, 8'h00, 1'b1, 16'h0303, 3'd3, 8'h00, 8'h00}, // R8 bit set long
    '{8'd8,  4'd11,3'd0, 3'd2, 8'h04, 8'h00, 16'h0300, 7'h00, 1'b1, 8'h00, 1'b0, 16'h0301, 3'd1, 8'h00, 8'h00}, // R8 bit clr fails
    '{8'd9,  4'd12,3'd0, 3'd0, 8'h00, 8'h00, 16'h0400, 7'h00, 1'b0, 8'h00, 1'b0, 16'h0401, 3'd4, 8'h80, 8'h00}, // R9 return
    '{8'd11, 4'd5, 3'd0, 3'd0, 8'h00, 8'h00, 16'hFFFE, 7'h05, 1'b0, 8'h01, 1'b1, 16'h0004, 3'd2, 8'h01, 8'h00}, // R11 wrap up
    '{8'd11, 4'd6, 3'd2, 3'd0, 8'h00, 8'h00, 16'h0001, 7'h7D, 1'b0, 8'h00, 1'b1, 16'hFFFF, 3'd2, 8'h00, 8'h00}, // R11 wrap down
    '{8'd2,  4'd1, 3'd4, 3'd0, 8'h00, 8'h00, 16'h0000, 7'h00, 1'b0, 8'h00, 1'b0, 16'h0001, 3'd1, 8'h10, 8'h00}  // R2 set S
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    alu_we = 1'b0; alu_mask = '0; alu_flags = '0;
    op_valid = 1'b0; op_code = '0;
  endtask

  task automatic preload(input logic [7:0] val);
    @(negedge clk);
    idle();
    alu_we = 1'b1; alu_mask = 8'hFF; alu_flags = val;
  endtask

  task automatic issue(input logic [3:0] op, input logic [2:0] fi,
                       input logic [2:0] bi, input logic [7:0] rv,
                       input logic [7:0] cv, input logic [15:0] pc,
                       input logic [6:0] ofs, input logic nl);
    @(negedge clk);
    idle();
    op_valid = 1'b1; op_code = op; flag_idx = fi; bit_idx = bi;
    reg_val = rv; cmp_val = cv; pc_in = pc; br_ofs = ofs; next_long = nl;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "sreg", 32'(sreg), 32'h00);
    check("R1", "res_valid", 32'(res_valid), 32'h0);
    check("R1", "taken", 32'(taken), 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", VECS[i].req);
      preload(VECS[i].pre);
      issue(VECS[i].op, VECS[i].fidx, VECS[i].bidx, VECS[i].rv, VECS[i].cv,
            VECS[i].pc, VECS[i].ofs, VECS[i].nl);
      @(negedge clk);
      idle();
      check(tag, "res_valid", 32'(res_valid), 32'h1);
      check(tag, "taken", 32'(taken), 32'(VECS[i].e_tk));
      check(tag, "next_pc", 32'(next_pc), 32'(VECS[i].e_pc));
      check(tag, "cycles", 32'(cycles), 32'(VECS[i].e_cy));
      check(tag, "sreg", 32'(sreg), 32'(VECS[i].e_sr));
      if (VECS[i].op == 4'd4) check(tag, "bld_value", 32'(bld_value), 32'(VECS[i].e_bld));
    end

    // R3 masked update alone
    preload(8'hFF);
    @(negedge clk);
    idle();
    alu_we = 1'b1; alu_mask = 8'h0F; alu_flags = 8'h00;
    @(negedge clk);
    idle();
    check("R3", "masked sreg", 32'(sreg), 32'hF0);
    check("R10", "no op no result", 32'(res_valid), 32'h0);
    // R3 same-cycle collision: update clears I and C, flag set on I wins
    issue(4'd1, 3'd7, 3'd0, 8'h00, 8'h00, 16'h0000, 7'h00, 1'b0);
    alu_we = 1'b1; alu_mask = 8'h81; alu_flags = 8'h00;
    @(negedge clk);
    idle();
    check("R3", "set beats update", 32'(sreg), 32'hF0);
    // R3 update sets T, flag clear on T wins
    issue(4'd2, 3'd6, 3'd0, 8'h00, 8'h00, 16'h0000, 7'h00, 1'b0);
    alu_we = 1'b1; alu_mask = 8'h40; alu_flags = 8'h40;
    @(negedge clk);
    idle();
    check("R3", "clear beats update", 32'(sreg), 32'hB0);

    // R10 branch reads flags from before the edge
    preload(8'h00);
    issue(4'd5, 3'd0, 3'd0, 8'h00, 8'h00, 16'h0100, 7'h05, 1'b0);
    alu_we = 1'b1; alu_mask = 8'h01; alu_flags = 8'h01;
    @(negedge clk);
    idle();
    check("R10", "old flags not taken", 32'(taken), 32'h0);
    check("R10", "old flags pc", 32'(next_pc), 32'h0101);
    check("R10", "update landed", 32'(sreg), 32'h01);
    issue(4'd5, 3'd0, 3'd0, 8'h00, 8'h00, 16'h0100, 7'h05, 1'b0);
    @(negedge clk);
    idle();
    check("R10", "next branch taken", 32'(taken), 32'h1);
    check("R10", "next branch pc", 32'(next_pc), 32'h0106);
    @(negedge clk);
    check("R10", "result lasts one cycle", 32'(res_valid), 32'h0);
    check("R10", "taken cleared", 32'(taken), 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule